// File: doc/BRIEF.md
# Virtual Address Control and Formatting Unit

This block sits beside the memory pipe of a 64-bit processor. It keeps a write-only control register with a page table base and three mode bits: big-endian, 48-bit address width and 32-bit format. It also keeps the virtual address of the most recent faulting access. Software reads back a formatted page-table-entry address. That address is built from the table base and the captured faulting address, and the mode bits decide which address bits are kept.

On the access side, every effective address is tested for proper sign extension above the active width, which is 43 or 48 bits. A failing address raises an access violation flag in the same cycle. In big-endian mode the block also flips the low physical address bits of a data access according to its size, and it inverts the 3-bit byte shift amount used by byte extract, insert and mask operations.

Top module: `va_ctl_unit`

## Requirements
- R1: A write with select 0 loads the table base from write data bits [63:30], the 32-bit format bit from bit 2, the 48-bit mode bit from bit 1 and the big-endian bit from bit 0. Write data bits [29:3] are discarded. Reset clears all stored control state to zero.
- R2: A read with select 0 returns zero, and so does a read with select 3.
- R3: When `fault_strobe` is high at a clock edge, the faulting address register loads `fault_va`. Otherwise it holds its value. A read with select 1 returns it.
- R4: With the 48-bit and 32-bit format bits both clear, a read with select 2 returns base bits [63:33] in [63:33] and faulting address bits [42:13] in [32:3]. Bits [2:0] are zero.
- R5: With 48-bit mode set and the 32-bit format bit clear, select 2 returns base bits [63:38] in [63:38] and faulting address bits [47:13] in [37:3]. Bits [2:0] are zero.
- R6: With the 32-bit format bit set, whatever the 48-bit mode, select 2 returns base bits [63:33] in [63:33] and faulting address bits [31:13] in [21:3]. Bits [32:22] and [2:0] are zero.
- R7: With 48-bit mode clear, `acc_violation` is high for a valid access whose bits [63:42] are not all equal.
- R8: With 48-bit mode set, `acc_violation` is high for a valid access whose bits [63:47] are not all equal. Addresses that are legal in this mode raise no violation, even when they are illegal in 43-bit mode.
- R9: `acc_violation` is low whenever `acc_valid` is low.
- R10: In big-endian mode, `acc_pa_out` equals `acc_pa_in` with some low bits inverted, chosen by `acc_size`. Size 0 (byte) inverts bits [2:0], size 1 (word) inverts bits [2:1] and size 2 (longword) inverts bit [2]. Higher bits pass unchanged.
- R11: Size 3 (quadword) accesses pass the physical address unchanged, and so does every access while big-endian mode is clear.
- R12: `shift_out` equals the bitwise inverse of `shift_in` in big-endian mode, and equals `shift_in` otherwise.
- R13: Read data is registered. `reg_rdata` takes the selected value at the edge where `reg_rd_en` is high, and holds it at all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 fault address, 2 formatted address, 3 none |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| fault_strobe | input | 1 | Capture strobe for the faulting address |
| fault_va | input | 64 | Faulting virtual address |
| acc_valid | input | 1 | Effective address is valid this cycle |
| acc_va | input | 64 | Effective virtual address |
| acc_violation | output | 1 | Sign-extension access violation |
| acc_size | input | 2 | Access size: 0 byte, 1 word, 2 longword, 3 quadword |
| acc_pa_in | input | 44 | Physical address before endian adjust |
| acc_pa_out | output | 44 | Physical address after endian adjust |
| shift_in | input | 3 | Byte shift amount |
| shift_out | output | 3 | Byte shift amount after endian adjust |

## Verification
The assertions check several rules on every cycle. No violation is raised on an idle cycle. The physical address above bit 2 is never altered, and it passes through untouched while big-endian mode is off. The faulting address is captured or held correctly, and control reads come back as zero. The bit layout of the formatted address in each of the three modes, the split between legal and illegal addresses at the 43-bit and 48-bit boundaries, and the fact that reserved write bits are discarded can only be shown by the bench's directed scenarios. Those scenarios compare the outputs against values worked out from the requirements.

// File: rtl/va_ctl_pkg.sv
package va_ctl_pkg;
  localparam int VA_W       = 64;
  localparam int BASE_LSB   = 30;
  localparam int BASE_W     = VA_W - BASE_LSB;
  localparam int PTE_SHIFT  = 3;
  localparam int PAGE_SHIFT = 13;
  localparam int NARROW_MSB = 42;
  localparam int WIDE_MSB   = 47;
  localparam int F32_MSB    = 31;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_FAULT  = 2'd1,
    SEL_FORMAT = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic              fmt32;
    logic              wide48;
    logic              big_end;
  } ctrl_t;
endpackage

// File: rtl/va_ctl_regs.sv
module va_ctl_regs
  import va_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      sel,
  input  logic [VA_W-1:0] wdata,
  input  logic            fault_strobe,
  input  logic [VA_W-1:0] fault_va,
  output ctrl_t           ctrl,
  output logic [VA_W-1:0] fault_q
);
  localparam int FMT32_BIT = 2;
  localparam int WIDE_BIT  = 1;
  localparam int BE_BIT    = 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en && sel == SEL_CTRL) begin
      ctrl.base    <= wdata[VA_W-1:BASE_LSB];
      ctrl.fmt32   <= wdata[FMT32_BIT];
      ctrl.wide48  <= wdata[WIDE_BIT];
      ctrl.big_end <= wdata[BE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= '0;
    end else if (fault_strobe) begin
      fault_q <= fault_va;
    end
  end

  AST_FAULT_LOAD: assert property (@(posedge clk) disable iff (rst)
    fault_strobe |=> fault_q == $past(fault_va)); // R3
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fault_strobe |=> $stable(fault_q)); // R3
  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_CTRL) |=> $stable(ctrl)); // R1
endmodule

// File: rtl/va_pte_format.sv
module va_pte_format
  import va_ctl_pkg::*;
(
  input  ctrl_t           ctrl,
  input  logic [VA_W-1:0] fault_q,
  output logic [VA_W-1:0] fmt
);
  localparam int N_W   = NARROW_MSB - PAGE_SHIFT + 1;
  localparam int W_W   = WIDE_MSB - PAGE_SHIFT + 1;
  localparam int F_W   = F32_MSB - PAGE_SHIFT + 1;
  localparam int N_TOP = PTE_SHIFT + N_W;
  localparam int W_TOP = PTE_SHIFT + W_W;
  localparam logic [VA_W-1:0] FULL_VA = {VA_W{1'b0}} | {VA_W{1'b1}};

  logic [VA_W-1:0] base_full;
  assign base_full = {ctrl.base, {BASE_LSB{1'b0}}};

  always_comb begin
    fmt = '0;
    if (ctrl.fmt32) begin
      fmt[VA_W-1:N_TOP]              = base_full[VA_W-1:N_TOP];
      fmt[PTE_SHIFT+F_W-1:PTE_SHIFT] = fault_q[F32_MSB:PAGE_SHIFT];
    end else if (ctrl.wide48) begin
      fmt[VA_W-1:W_TOP]              = base_full[VA_W-1:W_TOP];
      fmt[W_TOP-1:PTE_SHIFT]         = fault_q[WIDE_MSB:PAGE_SHIFT];
    end else begin
      fmt[VA_W-1:N_TOP]              = base_full[VA_W-1:N_TOP];
      fmt[N_TOP-1:PTE_SHIFT]         = fault_q[NARROW_MSB:PAGE_SHIFT];
    end
  end

  always_comb begin
    AST_FMT_ALIGNED: assert (fmt[PTE_SHIFT-1:0] == '0); // R4
    if (ctrl.fmt32)
      AST_FMT32_GAP: assert (fmt[N_TOP-1:PTE_SHIFT+F_W] == '0); // R6
  end
endmodule

// File: rtl/va_sext_check.sv
module va_sext_check
  import va_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic            wide48,
  input  logic [VA_W-1:0] va,
  output logic            violation
);
  localparam int NMODES = 2;
  localparam int MSBS [NMODES] = '{NARROW_MSB, WIDE_MSB};

  logic [NMODES-1:0] legal;

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    localparam int M = MSBS[m];
    assign legal[m] = (&va[VA_W-1:M]) | ~(|va[VA_W-1:M]);
  end

  assign violation = valid & ~legal[wide48];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !valid |-> !violation); // R9
  AST_WIDE_SUPERSET: assert property (@(posedge clk) disable iff (rst)
    (valid && wide48 && legal[0]) |-> !violation); // R8
endmodule

// File: rtl/va_endian_adj.sv
module va_endian_adj
  import va_ctl_pkg::*;
#(
  parameter int PA_W = 44,
  parameter int SH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            big_end,
  input  logic [1:0]      size,
  input  logic [PA_W-1:0] pa_in,
  output logic [PA_W-1:0] pa_out,
  input  logic [SH_W-1:0] shift_in,
  output logic [SH_W-1:0] shift_out
);
  logic [SH_W-1:0] flip;

  always_comb begin
    flip = '0;
    if (big_end) begin
      unique case (acc_size_e'(size))
        SZ_BYTE: flip = 3'b111;
        SZ_WORD: flip = 3'b110;
        SZ_LONG: flip = 3'b100;
        SZ_QUAD: flip = 3'b000;
        default: flip = '0;
      endcase
    end
  end

  assign pa_out    = {pa_in[PA_W-1:SH_W], pa_in[SH_W-1:0] ^ flip};
  assign shift_out = big_end ? ~shift_in : shift_in;

  AST_PA_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    pa_out[PA_W-1:SH_W] == pa_in[PA_W-1:SH_W]); // R10
  AST_LE_PASS: assert property (@(posedge clk) disable iff (rst)
    !big_end |-> (pa_out == pa_in && shift_out == shift_in)); // R11
  AST_QUAD_PASS: assert property (@(posedge clk) disable iff (rst)
    (size == SZ_QUAD) |-> pa_out == pa_in); // R11
endmodule

// File: rtl/va_ctl_unit.sv
module va_ctl_unit
  import va_ctl_pkg::*;
#(
  parameter int PA_W = 44
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [1:0]  reg_sel,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  input  logic        fault_strobe,
  input  logic [63:0] fault_va,
  input  logic        acc_valid,
  input  logic [63:0] acc_va,
  output logic        acc_violation,
  input  logic [1:0]  acc_size,
  input  logic [PA_W-1:0] acc_pa_in,
  output logic [PA_W-1:0] acc_pa_out,
  input  logic [2:0]  shift_in,
  output logic [2:0]  shift_out
);
  ctrl_t           ctrl;
  logic [VA_W-1:0] fault_q;
  logic [VA_W-1:0] fmt;
  logic [VA_W-1:0] rd_mux;

  va_ctl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .sel(reg_sel),
    .wdata(reg_wdata), .fault_strobe(fault_strobe), .fault_va(fault_va),
    .ctrl(ctrl), .fault_q(fault_q)
  );

  va_pte_format u_fmt (.ctrl(ctrl), .fault_q(fault_q), .fmt(fmt));

  va_sext_check u_sext (
    .clk(clk), .rst(rst), .valid(acc_valid), .wide48(ctrl.wide48),
    .va(acc_va), .violation(acc_violation)
  );

  va_endian_adj #(.PA_W(PA_W), .SH_W(3)) u_endian (
    .clk(clk), .rst(rst), .big_end(ctrl.big_end), .size(acc_size),
    .pa_in(acc_pa_in), .pa_out(acc_pa_out),
    .shift_in(shift_in), .shift_out(shift_out)
  );

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_FAULT:  rd_mux = fault_q;
      SEL_FORMAT: rd_mux = fmt;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end

  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_sel == SEL_CTRL) |=> reg_rdata == '0); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_en |=> $stable(reg_rdata)); // R13
endmodule

// File: tb/va_ctl_unit_tb.sv
module va_ctl_unit_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_wr_en = 0, reg_rd_en = 0;
  logic [1:0]  reg_sel = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic        fault_strobe = 0;
  logic [63:0] fault_va = 0;
  logic        acc_valid = 0;
  logic [63:0] acc_va = 0;
  logic        acc_violation;
  logic [1:0]  acc_size = 0;
  logic [43:0] acc_pa_in = 0, acc_pa_out;
  logic [2:0]  shift_in = 0, shift_out;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  va_ctl_unit u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [63:0] d);
    @(negedge clk); reg_wr_en = 1; reg_sel = 0; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] d);
    @(negedge clk); reg_rd_en = 1; reg_sel = s;
    @(negedge clk); reg_rd_en = 0; d = reg_rdata;
  endtask

  task automatic capture(input logic [63:0] va);
    @(negedge clk); fault_strobe = 1; fault_va = va;
    @(negedge clk); fault_strobe = 0; fault_va = ~va;
  endtask

  logic [63:0] base_img = 64'hA5C3_9E17_4000_0000;
  logic [63:0] fva      = 64'h0000_7ACE_F123_4567;

  task automatic t_reset();
    logic [63:0] d;
    rd(2'd2, d); chk("R1 reset format zero", d, 64'h0);
    rd(2'd1, d); chk("R1 reset fault zero", d, 64'h0);
    acc_size = 0; acc_pa_in = 44'h123_4567_89AB; shift_in = 3'b010;
    #1; chk("R1 reset little endian", {20'h0, acc_pa_out}, {20'h0, acc_pa_in});
  endtask

  task automatic t_fault();
    logic [63:0] d;
    capture(fva);
    repeat (3) @(negedge clk);
    rd(2'd1, d); chk("R3 fault capture/hold", d, fva);
  endtask

  task automatic t_formats();
    logic [63:0] d, e;
    wr_ctrl(base_img | 64'h3FFF_FFF8);
    rd(2'd0, d); chk("R2 ctrl reads zero", d, 64'h0);
    rd(2'd3, d); chk("R2 sel3 reads zero", d, 64'h0);
    rd(2'd2, d);
    e = {base_img[63:33], fva[42:13], 3'b000};
    chk("R4 R1 narrow format, reserved ignored", d, e);
    wr_ctrl(base_img | 64'h2);
    rd(2'd2, d);
    e = {base_img[63:38], fva[47:13], 3'b000};
    chk("R5 wide format", d, e);
    wr_ctrl(base_img | 64'h6);
    rd(2'd2, d);
    e = {base_img[63:33], 11'h0, fva[31:13], 3'b000};
    chk("R6 fmt32 with wide set", d, e);
    wr_ctrl(base_img | 64'h4);
    rd(2'd2, d); chk("R6 fmt32 with wide clear", d, e);
  endtask

  task automatic t_rdata_hold();
    logic [63:0] d;
    rd(2'd1, d);
    @(negedge clk); reg_sel = 2'd0; capture(64'h1111);
    @(negedge clk); chk("R13 rdata holds without read", reg_rdata, fva);
  endtask

  task automatic t_sext();
    wr_ctrl(64'h0);
    @(negedge clk); acc_valid = 1;
    acc_va = 64'hFFFF_FC00_0000_0000; #1; chk("R7 narrow neg legal", acc_violation, 0);
    acc_va = 64'h0000_03FF_FFFF_FFFF; #1; chk("R7 narrow pos legal", acc_violation, 0);
    acc_va = 64'h0000_0400_0000_0000; #1; chk("R7 narrow bit42 illegal", acc_violation, 1);
    acc_va = 64'h8000_0000_0000_0000; #1; chk("R7 narrow top illegal", acc_violation, 1);
    acc_valid = 0; #1; chk("R9 idle no violation", acc_violation, 0);
    wr_ctrl(64'h2);
    @(negedge clk); acc_valid = 1;
    acc_va = 64'h0000_0400_0000_0000; #1; chk("R8 wide accepts bit42", acc_violation, 0);
    acc_va = 64'hFFFF_8000_0000_0000; #1; chk("R8 wide neg legal", acc_violation, 0);
    acc_va = 64'h0000_8000_0000_0000; #1; chk("R8 wide bit47 illegal", acc_violation, 1);
    acc_valid = 0; #1; chk("R9 idle wide", acc_violation, 0);
  endtask

  task automatic t_endian();
    logic [43:0] p = 44'hABC_DEF0_1235;
    wr_ctrl(64'h1);
    @(negedge clk); acc_pa_in = p; shift_in = 3'b001;
    acc_size = 0; #1; chk("R10 byte", {20'h0, acc_pa_out}, {20'h0, p ^ 44'h7});
    acc_size = 1; #1; chk("R10 word", {20'h0, acc_pa_out}, {20'h0, p ^ 44'h6});
    acc_size = 2; #1; chk("R10 longword", {20'h0, acc_pa_out}, {20'h0, p ^ 44'h4});
    acc_size = 3; #1; chk("R11 quad unchanged", {20'h0, acc_pa_out}, {20'h0, p});
    chk("R12 shift inverted", {61'h0, shift_out}, 64'd6);
    wr_ctrl(64'h0);
    @(negedge clk); acc_size = 0; #1;
    chk("R11 little endian byte unchanged", {20'h0, acc_pa_out}, {20'h0, p});
    chk("R12 shift passes", {61'h0, shift_out}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_fault();
    t_formats();
    t_rdata_hold();
    t_sext();
    t_endian();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule